// File: doc/BRIEF.md
# Four-Level Prioritized Interrupt Controller

The block collects fifteen interrupt request lines into four priority levels. Level 0 is the most urgent and level 3 the least. Each line is first captured in a sticky cause bit. Its own enable mask bit then qualifies it, and the qualified bits of a level are combined into a registered level-pending flag. From those four flags the block produces a registered global interrupt request and a registered 2-bit code naming the most urgent pending level. Both outputs are qualified by a validity flag.

Sources are numbered globally. Index 0 is level 0. Indices 1 to 4 are level 1. Indices 5 to 10 are level 2, and indices 9 and 10 are that level's two sources whose enables are tied off. Indices 11 to 14 are level 3, and this whole group stays disabled unless the `L3_ENABLE` parameter is set. Software-visible enables are written one bit per source through a write-enable vector. Each cause bit is cleared by its own clear line. Identifying a device within a level, and looking up a vector, are left to logic downstream.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset all cause bits, `pend_o`, `irq_o` and `lvl_o` are 0, the validity flag is 1, and every programmable enable bit is 1.
- R2: A high `req_i[i]` sampled at a clock edge sets cause bit i at that edge. The bit stays set until `clr_i[i]` is sampled high. If request and clear are high in the same cycle, the bit stays set.
- R3: `pend_o[l]` (bit l is level l) is a register holding the OR of the enabled cause bits of level l. A request sampled at edge n shows on `pend_o` at edge n+1.
- R4: `mask_wdata_i[i]` is written into enable bit i at an edge where `mask_we_i[i]` is 1. Bits with `mask_we_i` at 0 keep their value. A disabled cause bit does not contribute to pending, but it stays latched and contributes again once it is re-enabled.
- R5: Level-2 sources at local positions 4 and 5 (global 9 and 10) never make a level pending, whatever is written to their enables.
- R6: With `L3_ENABLE` = 0 (the default), sources 11 to 14 never make level 3 pending.
- R7: `irq_o` is registered. It equals the OR of `pend_o` ANDed with the validity flag, one edge later.
- R8: `lvl_o` is registered. It is the binary index of the lowest-numbered pending level, ANDed with the validity flag, one edge later. It is 00 when nothing is pending, and `irq_o` separates that idle case from level 0 pending.
- R9: The validity flag is written from `valid_wdata_i` when `valid_we_i` is 1. While it is 0, the next `irq_o` and `lvl_o` are 0 and `pend_o` is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 15 | Per-source request lines |
| clr_i | input | 15 | Per-source cause clear |
| mask_we_i | input | 15 | Per-source enable write strobe |
| mask_wdata_i | input | 15 | Enable write data |
| valid_we_i | input | 1 | Validity flag write strobe |
| valid_wdata_i | input | 1 | Validity flag write data |
| pend_o | output | 4 | Registered level-pending flags |
| irq_o | output | 1 | Registered global request |
| lvl_o | output | 2 | Registered most urgent pending level |

## Verification
The bench counts the pipeline from request to cause, to pending, to the request output. A design with a missing or extra register stage would present `pend_o` or `irq_o` one cycle off. It raises two and then three levels at once to confirm that level 0 wins and is told apart from idle by `irq_o`; an encoder with reversed priority would report the higher-numbered level. It pulses request and clear together on a set cause, which a clear-wins design would drop. It also disables a latched cause and re-enables it, which a design that gates before latching would lose. Finally, it writes enables onto the tied-off level-2 sources and requests the disabled level-3 group, and it drops the validity flag while a level stays pending; leaky gating would show up on `pend_o`, `irq_o` or `lvl_o`.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned NUM_LVL = 4;
  localparam int unsigned LVL_W   = $clog2(NUM_LVL);
  typedef logic [LVL_W-1:0] lvl_code_t;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int unsigned N_SRC = 15,
  parameter logic [N_SRC-1:0] ALLOW = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] clr_i,
  input  logic [N_SRC-1:0] mask_we_i,
  input  logic [N_SRC-1:0] mask_wdata_i,
  output logic [N_SRC-1:0] cause_o,
  output logic [N_SRC-1:0] mask_o,
  output logic [N_SRC-1:0] masked_o
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    logic cause_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cause_q <= 1'b0;
      else         cause_q <= req_i[i] | (cause_q & ~clr_i[i]);  // set wins
    end
    assign cause_o[i] = cause_q;

    if (ALLOW[i]) begin : g_prog
      logic mask_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          mask_q <= 1'b1;
        else if (mask_we_i[i]) mask_q <= mask_wdata_i[i];
      end
      assign mask_o[i] = mask_q;
    end else begin : g_tied
      assign mask_o[i] = 1'b0;
    end

    assign masked_o[i] = cause_q & mask_o[i];
  end
endmodule

// File: rtl/irq_lvl_merge.sv
module irq_lvl_merge #(
  parameter int unsigned N_SRC = 15,
  parameter int unsigned N_LVL = 4,
  parameter logic [N_LVL*N_SRC-1:0] SEL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] masked_i,
  output logic [N_LVL-1:0] pend_o
);
  for (genvar l = 0; l < N_LVL; l++) begin : g_lvl
    localparam logic [N_SRC-1:0] LSEL = SEL[l*N_SRC +: N_SRC];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_o[l] <= 1'b0;
      else         pend_o[l] <= |(masked_i & LSEL);
    end
  end
endmodule

// File: rtl/irq_prio_out.sv
module irq_prio_out
  import irq_pkg::*;
#(
  parameter int unsigned N_LVL = NUM_LVL,
  localparam int unsigned W = $clog2(N_LVL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] pend_i,
  input  logic             valid_i,
  output logic             irq_o,
  output logic [W-1:0]     lvl_o
);
  logic [W-1:0] code;

  // lowest index wins: scan from the bottom of the priority order upward
  always_comb begin
    code = '0;
    for (int l = N_LVL - 1; l >= 0; l--) begin
      if (pend_i[l]) code = W'(l);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      lvl_o <= '0;
    end else begin
      irq_o <= (|pend_i) & valid_i;
      lvl_o <= code & {W{valid_i}};
    end
  end
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_L0 = 1,
  parameter int unsigned N_L1 = 4,
  parameter int unsigned N_L2 = 6,
  parameter int unsigned N_L3 = 4,
  parameter bit          L3_ENABLE = 1'b0,
  localparam int unsigned N_SRC = N_L0 + N_L1 + N_L2 + N_L3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   req_i,
  input  logic [N_SRC-1:0]   clr_i,
  input  logic [N_SRC-1:0]   mask_we_i,
  input  logic [N_SRC-1:0]   mask_wdata_i,
  input  logic               valid_we_i,
  input  logic               valid_wdata_i,
  output logic [NUM_LVL-1:0] pend_o,
  output logic               irq_o,
  output logic [LVL_W-1:0]   lvl_o
);
  localparam int unsigned B1 = N_L0;
  localparam int unsigned B2 = B1 + N_L1;
  localparam int unsigned B3 = B2 + N_L2;

  function automatic logic [NUM_LVL*N_SRC-1:0] sel_vec();
    logic [NUM_LVL*N_SRC-1:0] v = '0;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (i < int'(B1))      v[0*N_SRC + i] = 1'b1;
      else if (i < int'(B2)) v[1*N_SRC + i] = 1'b1;
      else if (i < int'(B3)) v[2*N_SRC + i] = 1'b1;
      else                   v[3*N_SRC + i] = 1'b1;
    end
    return v;
  endfunction

  function automatic logic [N_SRC-1:0] allow_vec();
    logic [N_SRC-1:0] v = '1;
    for (int i = 0; i < int'(N_SRC); i++) begin
      if (i == int'(B2) + 4 || i == int'(B2) + 5) v[i] = 1'b0;  // unwired level-2 slots
      if (i >= int'(B3) && !L3_ENABLE)            v[i] = 1'b0;
    end
    return v;
  endfunction

  localparam logic [NUM_LVL*N_SRC-1:0] SEL   = sel_vec();
  localparam logic [N_SRC-1:0]         ALLOW = allow_vec();

  logic [N_SRC-1:0] cause_q, mask_eff, masked;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         valid_q <= 1'b1;
    else if (valid_we_i) valid_q <= valid_wdata_i;
  end

  irq_src_bank #(.N_SRC(N_SRC), .ALLOW(ALLOW)) u_bank (
    .clk_i, .rst_ni, .req_i, .clr_i, .mask_we_i, .mask_wdata_i,
    .cause_o(cause_q), .mask_o(mask_eff), .masked_o(masked)
  );

  irq_lvl_merge #(.N_SRC(N_SRC), .N_LVL(NUM_LVL), .SEL(SEL)) u_merge (
    .clk_i, .rst_ni, .masked_i(masked), .pend_o
  );

  irq_prio_out #(.N_LVL(NUM_LVL)) u_out (
    .clk_i, .rst_ni, .pend_i(pend_o), .valid_i(valid_q), .irq_o, .lvl_o
  );
endmodule

// File: rtl/irq_level_ctrl_chk.sv
module irq_level_ctrl_chk #(
  parameter int unsigned N_SRC = 15,
  parameter logic [N_SRC-1:0] ALLOW = '1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SRC-1:0] req_i,
  input logic [N_SRC-1:0] cause_i,
  input logic [N_SRC-1:0] mask_eff_i,
  input logic [3:0]       pend_i,
  input logic             irq_i,
  input logic [1:0]       lvl_i,
  input logic             valid_i
);
  // R2: every sampled request is latched at the next edge
  a_r2_cause_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((cause_i & $past(req_i)) == $past(req_i)));

  // R3: level 0 pending tracks its single enabled cause one edge later
  a_r3_lvl0_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_i[0] == $past(cause_i[0] & mask_eff_i[0])));

  // R5 / R6: tied-off enables never read as 1
  a_r5_tied_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_eff_i & ~ALLOW) == '0);

  // R7: global request follows pending and validity
  a_r7_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == ($past(|pend_i) & $past(valid_i))));

  // R8: idle gives code 00
  a_r8_idle_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_i |-> (lvl_i == 2'd0));

  // R8: level 1 alone reports code 01
  a_r8_lvl1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_i[1:0] == 2'b10 && valid_i) |=> (lvl_i == 2'd1 && irq_i));

  // R9: cleared validity forces outputs low
  a_r9_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!irq_i && lvl_i == 2'd0));
endmodule

bind irq_level_ctrl irq_level_ctrl_chk #(.N_SRC(N_SRC), .ALLOW(ALLOW)) u_chk (
  .clk_i, .rst_ni, .req_i,
  .cause_i(cause_q), .mask_eff_i(mask_eff),
  .pend_i(pend_o), .irq_i(irq_o), .lvl_i(lvl_o), .valid_i(valid_q)
);

// File: tb/tb_irq_level_ctrl.sv
module tb_irq_level_ctrl;
  localparam int N = 15;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  req_i = '0, clr_i = '0, mask_we_i = '0, mask_wdata_i = '0;
  logic          valid_we_i = 1'b0, valid_wdata_i = 1'b0;
  logic [3:0]    pend_o;
  logic          irq_o;
  logic [1:0]    lvl_o;

  irq_level_ctrl dut (.*);

  always #2 clk_i = ~clk_i;  // 250 MHz

  typedef struct {
    int         due;
    logic [3:0] pend;
    logic       irq;
    logic [1:0] lvl;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0, t0 = 0, checks = 0, errors = 0;
  bit   done = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic pulse(input logic [N-1:0] rq, input logic [N-1:0] cl,
                       input logic [N-1:0] we, input logic [N-1:0] wd,
                       input logic vwe, input logic vwd);
    @(negedge clk_i);
    req_i = rq; clr_i = cl; mask_we_i = we; mask_wdata_i = wd;
    valid_we_i = vwe; valid_wdata_i = vwd;
    t0 = cyc;
    @(negedge clk_i);
    req_i = '0; clr_i = '0; mask_we_i = '0; mask_wdata_i = '0;
    valid_we_i = 1'b0; valid_wdata_i = 1'b0;
  endtask

  task automatic expect_at(input int k, input logic [3:0] p, input logic i,
                           input logic [1:0] l, input string tag);
    exp_t e;
    e.due = t0 + k; e.pend = p; e.irq = i; e.lvl = l; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: compares at the falling edge of the due cycle
  always @(negedge clk_i) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (e.due != cyc) begin
        errors++;
        $display("FAIL %s missed slot: due %0d now %0d", e.tag, e.due, cyc);
      end else if (pend_o !== e.pend || irq_o !== e.irq || lvl_o !== e.lvl) begin
        errors++;
        $display("FAIL %s: pend=%b irq=%b lvl=%0d expected pend=%b irq=%b lvl=%0d",
                 e.tag, pend_o, irq_o, lvl_o, e.pend, e.irq, e.lvl);
      end
    end
  end

  function automatic logic [N-1:0] b(input int i);
    return N'(1) << i;
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t0 = cyc;
    expect_at(1, 4'b0000, 1'b0, 2'd0, "R1 reset state");
    idle(2);

    // single level-2 source, default enables; exact pipeline timing
    pulse(b(6), '0, '0, '0, 1'b0, 1'b0);
    expect_at(1, 4'b0000, 1'b0, 2'd0, "R3 not yet pending");
    expect_at(2, 4'b0100, 1'b0, 2'd0, "R3 pending after one stage");
    expect_at(3, 4'b0100, 1'b1, 2'd2, "R7 R8 irq and code level 2");
    expect_at(6, 4'b0100, 1'b1, 2'd2, "R2 cause held after request drops");
    idle(6);

    pulse(b(2), '0, '0, '0, 1'b0, 1'b0);
    expect_at(3, 4'b0110, 1'b1, 2'd1, "R8 level 1 beats level 2");
    idle(4);
    pulse(b(0), '0, '0, '0, 1'b0, 1'b0);
    expect_at(3, 4'b0111, 1'b1, 2'd0, "R8 level 0 wins with irq high");
    idle(4);
    pulse('0, b(0), '0, '0, 1'b0, 1'b0);
    expect_at(2, 4'b0110, 1'b1, 2'd0, "R2 clear drops level 0 pending");
    expect_at(3, 4'b0110, 1'b1, 2'd1, "R8 code falls back to level 1");
    idle(4);

    // set and clear together: set wins
    pulse(b(2), b(2), '0, '0, 1'b0, 1'b0);
    expect_at(4, 4'b0110, 1'b1, 2'd1, "R2 set wins over clear");
    idle(5);
    pulse('0, b(2) | b(6), '0, '0, 1'b0, 1'b0);
    expect_at(3, 4'b0000, 1'b0, 2'd0, "R8 idle after clearing all");
    idle(4);

    // disable source 7, request it, re-enable it
    pulse('0, '0, b(7) | b(1), '0, 1'b0, 1'b0);
    idle(1);
    pulse(b(7), '0, '0, '0, 1'b0, 1'b0);
    expect_at(4, 4'b0000, 1'b0, 2'd0, "R4 disabled cause not pending");
    idle(5);
    pulse('0, '0, b(7), b(7), 1'b0, 1'b0);
    expect_at(2, 4'b0100, 1'b0, 2'd0, "R4 latched cause counts after enable");
    expect_at(3, 4'b0100, 1'b1, 2'd2, "R4 irq after enable");
    idle(4);
    pulse('0, b(7), '0, '0, 1'b0, 1'b0);
    idle(3);
    // enable 1 was written to 0 above; mask_we 0 must not change it
    pulse(b(1), '0, '0, b(1), 1'b0, 1'b0);
    expect_at(4, 4'b0000, 1'b0, 2'd0, "R4 write without strobe ignored");
    idle(5);
    pulse('0, '0, b(1), b(1), 1'b0, 1'b0);
    expect_at(3, 4'b0010, 1'b1, 2'd1, "R4 re-enabled level 1 source");
    idle(4);
    pulse('0, b(1), '0, '0, 1'b0, 1'b0);
    idle(3);

    // tied-off level-2 slots
    pulse(b(9) | b(10), '0, b(9) | b(10), b(9) | b(10), 1'b0, 1'b0);
    expect_at(4, 4'b0000, 1'b0, 2'd0, "R5 tied-off level 2 sources");
    idle(5);
    // level 3 disabled by default
    pulse(b(11) | b(12) | b(13) | b(14), '0, b(11) | b(14), b(11) | b(14), 1'b0, 1'b0);
    expect_at(4, 4'b0000, 1'b0, 2'd0, "R6 level 3 disabled");
    idle(5);
    pulse('0, '1, '0, '0, 1'b0, 1'b0);
    idle(3);

    // validity flag
    pulse(b(3), '0, '0, '0, 1'b0, 1'b0);
    expect_at(3, 4'b0010, 1'b1, 2'd1, "R9 baseline valid");
    idle(4);
    pulse('0, '0, '0, '0, 1'b1, 1'b0);
    expect_at(2, 4'b0010, 1'b0, 2'd0, "R9 invalid masks irq and code");
    expect_at(4, 4'b0010, 1'b0, 2'd0, "R9 pending unaffected");
    idle(5);
    pulse('0, '0, '0, '0, 1'b1, 1'b1);
    expect_at(2, 4'b0010, 1'b1, 2'd1, "R9 restored validity");
    idle(4);

    while (sb.size() > 0) @(negedge clk_i);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++; errors++;
        $display("FAIL watchdog expired: got timeout expected completion");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule